// File: doc/BRIEF.md
# Three-Stage Predicated Integer Core

This block is a small in-order processor core with three stages: fetch, decode and execute. It holds sixteen 32-bit registers and a four-bit flag register with negative, zero, carry and overflow flags. It runs a small instruction set: register add, register subtract, register move, compare, and a relative branch. Every instruction carries a four-bit condition field. The execute stage tests that field against the flags. When the test fails, the instruction retires with no effect.

Instructions come from a synchronous instruction memory. The core drives a byte address on `imem_addr`, and the word at that address must appear on `imem_rdata` one clock later. The memory port has no handshake: the memory must answer every cycle. Each instruction that leaves execute is reported on the retire outputs for one cycle. This retire stream has no ready input and cannot be back-pressured, so an observer must take each beat in the cycle it is valid. Register 15 is never a storage location for a reader: reading it gives the address of the executing instruction plus eight, which is the address fetch is reading at that moment.

Instruction word layout: bits [31:28] hold the condition, bits [27:24] the opcode, bits [23:20] rd, bits [19:16] rn, bits [15:12] rm, and bit 11 the set-flags bit. For a branch, bits [23:0] hold a signed word offset.

Top module: `pipe3_core`

## Requirements
- R1: Reset is synchronous and active high. While reset is held, `imem_addr` is 0, `retire_valid` is 0, `flags` is 0 and every register reads 0. Count the first rising edge with reset low as edge 1. The instruction at address 0 then retires (is on the retire outputs) in the cycle after edge 2, which is the third cycle.
- R2: When no branch is taken, the fetch address steps up by 4 on each clock edge.
- R3: When an instruction reads register 15 as a source, the value is that instruction's own address plus 8.
- R4: The opcodes are 0 = ADD (rd = rn + rm), 1 = SUB (rd = rn - rm) and 2 = MOV (rd = rm). The result is written at the end of execute. The next instruction reads the new value with no stall.
- R5: Opcode 3 = CMP computes rn - rm and sets the flags from the result: N is the sign bit, Z means the result is zero, C means no borrow, and V means signed overflow. CMP writes no register. The `flags` output packs them as {N, Z, C, V} in bits [3:0].
- R6: ADD and SUB change the flags only when bit 11 is 1. ADD sets C to the carry out. With bit 11 at 0, and for MOV, the flags are unchanged.
- R7: The condition codes are 0 EQ (Z), 1 NE (!Z), 2 CS (C), 3 CC (!C), 4 MI, 5 PL, 6 VS, 7 VC, 8 HI, 9 LS, A GE, B LT, C GT, D LE, E always and F never. An instruction whose condition fails still retires, but writes no register and leaves the flags unchanged.
- R8: A branch (opcode 4) whose condition fails is not taken (`retire_taken` = 0). Fetch continues in sequence.
- R9: A branch whose condition passes redirects fetch to its own address + 8 + 4 × offset. The two younger instructions already in flight never retire. The target retires three cycles after the branch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| imem_addr | output | 32 | Byte address being fetched |
| imem_rdata | input | 32 | Instruction word for the address of the previous cycle |
| flags | output | 4 | Current {N, Z, C, V} |
| retire_valid | output | 1 | An instruction is leaving execute this cycle |
| retire_pc | output | 32 | Address of the retiring instruction |
| retire_taken | output | 1 | The retiring instruction is a taken branch |
| retire_wen | output | 1 | The retiring instruction writes a register |
| retire_rd | output | 4 | Destination register index |
| retire_data | output | 32 | Value written (valid with retire_wen) |
| retire_flags | output | 4 | Flags as they stand after this instruction |

## Verification
The assertions assume that the memory returns a word on every cycle, exactly one clock after the address, and that reset is held for at least one edge. The bench meets both assumptions with a register-backed instruction array that it reads on every rising edge. The array is loaded only while reset is held. Any unused locations are filled with never-execute words, so no run reaches an undefined instruction. The branch program ends in a branch to itself, which keeps the retire stream active without ever leaving the loaded code.

// File: rtl/pipe3_pkg.sv
package pipe3_pkg;
  localparam int RIDX_W = 4;
  localparam int NFLAG  = 4;
  localparam int INSN_BYTES = 4;

  localparam int FN = 3;
  localparam int FZ = 2;
  localparam int FC = 1;
  localparam int FV = 0;

  typedef enum logic [3:0] {
    OP_ADD = 4'd0,
    OP_SUB = 4'd1,
    OP_MOV = 4'd2,
    OP_CMP = 4'd3,
    OP_BR  = 4'd4
  } opcode_e;

  typedef struct packed {
    logic [3:0]        cond;
    logic [3:0]        op;
    logic [RIDX_W-1:0] rd;
    logic [RIDX_W-1:0] rn;
    logic [RIDX_W-1:0] rm;
    logic              setf;
    logic [23:0]       off;
  } dec_t;

  function automatic dec_t decode(input logic [31:0] w);
    dec_t d;
    d.cond = w[31:28];
    d.op   = w[27:24];
    d.rd   = w[23:20];
    d.rn   = w[19:16];
    d.rm   = w[15:12];
    d.setf = w[11];
    d.off  = w[23:0];
    return d;
  endfunction
endpackage

// File: rtl/pipe3_cond.sv
module pipe3_cond
  import pipe3_pkg::*;
(
  input  logic [3:0]       cond,
  input  logic [NFLAG-1:0] fl,
  output logic             pass
);
  logic n, z, c, v;
  assign n = fl[FN];
  assign z = fl[FZ];
  assign c = fl[FC];
  assign v = fl[FV];

  always_comb begin
    case (cond)
      4'h0: pass = z;
      4'h1: pass = !z;
      4'h2: pass = c;
      4'h3: pass = !c;
      4'h4: pass = n;
      4'h5: pass = !n;
      4'h6: pass = v;
      4'h7: pass = !v;
      4'h8: pass = c && !z;
      4'h9: pass = !c || z;
      4'hA: pass = (n == v);
      4'hB: pass = (n != v);
      4'hC: pass = !z && (n == v);
      4'hD: pass = z || (n != v);
      4'hE: pass = 1'b1;
      default: pass = 1'b0;
    endcase
  end
endmodule

// File: rtl/pipe3_alu.sv
module pipe3_alu
  import pipe3_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic [3:0]       op,
  input  logic [XLEN-1:0]  a,
  input  logic [XLEN-1:0]  b,
  output logic [XLEN-1:0]  res,
  output logic [NFLAG-1:0] nf
);
  localparam int MSB = XLEN - 1;

  logic [XLEN:0] sum, diff;
  logic c, v;

  assign sum  = {1'b0, a} + {1'b0, b};
  assign diff = {1'b0, a} - {1'b0, b};

  always_comb begin
    res = '0;
    c   = 1'b0;
    v   = 1'b0;
    case (op)
      OP_ADD: begin
        res = sum[MSB:0];
        c   = sum[XLEN];
        v   = (a[MSB] == b[MSB]) && (sum[MSB] != a[MSB]);
      end
      OP_SUB, OP_CMP: begin
        res = diff[MSB:0];
        c   = ~diff[XLEN];
        v   = (a[MSB] != b[MSB]) && (diff[MSB] != a[MSB]);
      end
      OP_MOV: res = b;
      default: res = '0;
    endcase
  end

  always_comb begin
    nf     = '0;
    nf[FN] = res[MSB];
    nf[FZ] = (res == '0);
    nf[FC] = c;
    nf[FV] = v;
  end
endmodule

// File: rtl/pipe3_regfile.sv
module pipe3_regfile
  import pipe3_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [XLEN-1:0]   pc_view,
  input  logic [RIDX_W-1:0] ra,
  input  logic [RIDX_W-1:0] rb,
  output logic [XLEN-1:0]   ra_val,
  output logic [XLEN-1:0]   rb_val,
  input  logic              we,
  input  logic [RIDX_W-1:0] wa,
  input  logic [XLEN-1:0]   wd
);
  localparam int NREG = 1 << RIDX_W;
  localparam logic [RIDX_W-1:0] PC_IDX = RIDX_W'(NREG - 1);

  logic [XLEN-1:0] regs [NREG];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREG; i++) regs[i] <= '0;
    end else if (we) begin
      regs[wa] <= wd;
    end
  end

  assign ra_val = (ra == PC_IDX) ? pc_view : regs[ra];
  assign rb_val = (rb == PC_IDX) ? pc_view : regs[rb];
endmodule

// File: rtl/pipe3_fetch.sv
module pipe3_fetch
  import pipe3_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            redirect,
  input  logic [XLEN-1:0] target,
  output logic [XLEN-1:0] fetch_pc,
  output logic            dec_valid,
  output logic [XLEN-1:0] dec_pc
);
  localparam logic [XLEN-1:0] STEP = XLEN'(INSN_BYTES);

  always_ff @(posedge clk) begin
    if (rst) begin
      fetch_pc  <= '0;
      dec_valid <= 1'b0;
      dec_pc    <= '0;
    end else begin
      dec_valid <= !redirect;
      dec_pc    <= fetch_pc;
      fetch_pc  <= redirect ? target : fetch_pc + STEP;
    end
  end

  AST_DECODE_TRAILS_FETCH: assert property (@(posedge clk) disable iff (rst)
    dec_valid |-> fetch_pc == dec_pc + STEP); // R2
endmodule

// File: rtl/pipe3_core.sv
module pipe3_core
  import pipe3_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic              clk,
  input  logic              rst,
  output logic [XLEN-1:0]   imem_addr,
  input  logic [31:0]       imem_rdata,
  output logic [NFLAG-1:0]  flags,
  output logic              retire_valid,
  output logic [XLEN-1:0]   retire_pc,
  output logic              retire_taken,
  output logic              retire_wen,
  output logic [RIDX_W-1:0] retire_rd,
  output logic [XLEN-1:0]   retire_data,
  output logic [NFLAG-1:0]  retire_flags
);
  localparam logic [XLEN-1:0] LEAD = XLEN'(2 * INSN_BYTES);
  localparam int SEXT_W = XLEN - 26;

  logic            d_valid;
  logic [XLEN-1:0] d_pc;
  logic            redirect;
  logic [XLEN-1:0] target;

  pipe3_fetch #(.XLEN(XLEN)) u_fetch (
    .clk(clk), .rst(rst), .redirect(redirect), .target(target),
    .fetch_pc(imem_addr), .dec_valid(d_valid), .dec_pc(d_pc)
  );

  logic            ex_valid;
  logic [XLEN-1:0] ex_pc;
  logic [31:0]     ex_word;

  always_ff @(posedge clk) begin
    if (rst) begin
      ex_valid <= 1'b0;
      ex_pc    <= '0;
      ex_word  <= '0;
    end else begin
      ex_valid <= d_valid && !redirect;
      ex_pc    <= d_pc;
      ex_word  <= imem_rdata;
    end
  end

  dec_t            dec;
  logic [XLEN-1:0] pc_view, a_val, b_val, alu_res;
  logic [NFLAG-1:0] alu_fl;
  logic            pass, exec_ok, writes_rd, sets_fl, wen, flag_we;

  assign dec     = decode(ex_word);
  assign pc_view = ex_pc + LEAD;

  pipe3_cond u_cond (.cond(dec.cond), .fl(flags), .pass(pass));

  pipe3_regfile #(.XLEN(XLEN)) u_rf (
    .clk(clk), .rst(rst), .pc_view(pc_view),
    .ra(dec.rn), .rb(dec.rm), .ra_val(a_val), .rb_val(b_val),
    .we(wen), .wa(dec.rd), .wd(alu_res)
  );

  pipe3_alu #(.XLEN(XLEN)) u_alu (
    .op(dec.op), .a(a_val), .b(b_val), .res(alu_res), .nf(alu_fl)
  );

  assign writes_rd = (dec.op == OP_ADD) || (dec.op == OP_SUB) || (dec.op == OP_MOV);
  assign sets_fl   = (dec.op == OP_CMP) ||
                     (((dec.op == OP_ADD) || (dec.op == OP_SUB)) && dec.setf);
  assign exec_ok   = ex_valid && pass;
  assign wen       = exec_ok && writes_rd;
  assign flag_we   = exec_ok && sets_fl;
  assign redirect  = exec_ok && (dec.op == OP_BR);
  assign target    = pc_view + {{SEXT_W{dec.off[23]}}, dec.off, 2'b00};

  always_ff @(posedge clk) begin
    if (rst) flags <= '0;
    else if (flag_we) flags <= alu_fl;
  end

  assign retire_valid = ex_valid;
  assign retire_pc    = ex_pc;
  assign retire_taken = redirect;
  assign retire_wen   = wen;
  assign retire_rd    = dec.rd;
  assign retire_data  = alu_res;
  assign retire_flags = flag_we ? alu_fl : flags;

  AST_FETCH_LEADS_EXEC: assert property (@(posedge clk) disable iff (rst)
    (ex_valid && d_valid) |-> imem_addr == ex_pc + LEAD); // R3
  AST_FAIL_KEEPS_FLAGS: assert property (@(posedge clk) disable iff (rst)
    (ex_valid && !pass) |=> $stable(flags)); // R7
  AST_NOSET_KEEPS_FLAGS: assert property (@(posedge clk) disable iff (rst)
    (ex_valid && dec.op != OP_CMP && !dec.setf) |=> $stable(flags)); // R6
  AST_TAKEN_SQUASH: assert property (@(posedge clk) disable iff (rst)
    redirect |=> (!ex_valid && !d_valid)); // R9
  AST_TAKEN_TARGET: assert property (@(posedge clk) disable iff (rst)
    redirect |=> imem_addr == $past(target)); // R9
endmodule

// File: tb/tb_pipe3_core.sv
`timescale 1ns/1ps
module tb_pipe3_core;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  logic [31:0] imem_addr, imem_rdata, retire_pc, retire_data;
  logic [3:0]  flags, retire_rd, retire_flags;
  logic        retire_valid, retire_taken, retire_wen;

  pipe3_core dut (
    .clk(clk), .rst(rst), .imem_addr(imem_addr), .imem_rdata(imem_rdata),
    .flags(flags), .retire_valid(retire_valid), .retire_pc(retire_pc),
    .retire_taken(retire_taken), .retire_wen(retire_wen), .retire_rd(retire_rd),
    .retire_data(retire_data), .retire_flags(retire_flags)
  );

  logic [31:0] imem [0:63];
  always_ff @(posedge clk) imem_rdata <= imem[imem_addr[7:2]];

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  always @(posedge clk) begin
    if (rst) cyc <= 0;
    else cyc <= cyc + 1;
  end

  int          n = 0;
  logic [31:0] r_pc [0:31];
  logic [31:0] r_data [0:31];
  logic [3:0]  r_rd [0:31];
  logic [3:0]  r_fl [0:31];
  logic        r_wen [0:31];
  logic        r_tk [0:31];
  int          r_cyc [0:31];

  always @(negedge clk) begin
    if (!rst && retire_valid && n < 32) begin
      r_pc[n] = retire_pc;  r_data[n] = retire_data; r_rd[n] = retire_rd;
      r_fl[n] = retire_flags; r_wen[n] = retire_wen; r_tk[n] = retire_taken;
      r_cyc[n] = cyc;
      n = n + 1;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] enc(input logic [3:0] c, input logic [3:0] op,
      input logic [3:0] rd, input logic [3:0] rn, input logic [3:0] rm, input logic s);
    return {c, op, rd, rn, rm, s, 11'b0};
  endfunction

  typedef struct packed {
    logic [3:0] cond; logic [3:0] op; logic [3:0] rd; logic [3:0] rn; logic [3:0] rm;
    logic s; logic ewen; logic [3:0] erd; logic [31:0] edata; logic [3:0] efl;
  } vec_t;

  // Straight-line program, one entry per word starting at address 0.
  localparam int NV = 16;
  localparam vec_t VEC [0:NV-1] = '{
    '{4'hE, 4'd2, 4'd1,  4'd0,  4'd15, 1'b0, 1'b1, 4'd1,  32'd8,        4'h0}, // R3 MOV r1,r15
    '{4'hE, 4'd2, 4'd2,  4'd0,  4'd15, 1'b0, 1'b1, 4'd2,  32'd12,       4'h0}, // R3
    '{4'hE, 4'd0, 4'd3,  4'd1,  4'd2,  1'b0, 1'b1, 4'd3,  32'd20,       4'h0}, // R4 back-to-back
    '{4'hE, 4'd1, 4'd4,  4'd1,  4'd2,  1'b1, 1'b1, 4'd4,  32'hFFFFFFFC, 4'h8}, // R6 SUBS
    '{4'hE, 4'd3, 4'd0,  4'd1,  4'd1,  1'b0, 1'b0, 4'd0,  32'd0,        4'h6}, // R5 CMP equal
    '{4'h0, 4'd2, 4'd5,  4'd0,  4'd3,  1'b0, 1'b1, 4'd5,  32'd20,       4'h6}, // R7 EQ pass
    '{4'h1, 4'd2, 4'd6,  4'd0,  4'd3,  1'b0, 1'b0, 4'd0,  32'd0,        4'h6}, // R7 NE fail
    '{4'hE, 4'd0, 4'd7,  4'd3,  4'd3,  1'b0, 1'b1, 4'd7,  32'd40,       4'h6}, // R6 no S
    '{4'hE, 4'd3, 4'd0,  4'd1,  4'd2,  1'b0, 1'b0, 4'd0,  32'd0,        4'h8}, // R5 CMP less
    '{4'h1, 4'd0, 4'd8,  4'd15, 4'd1,  1'b0, 1'b1, 4'd8,  32'd52,       4'h8}, // R3 R7 NE pass
    '{4'h0, 4'd1, 4'd8,  4'd1,  4'd1,  1'b1, 1'b0, 4'd0,  32'd0,        4'h8}, // R7 fail keeps flags
    '{4'hE, 4'd2, 4'd9,  4'd0,  4'd8,  1'b0, 1'b1, 4'd9,  32'd52,       4'h8}, // R7 r8 untouched
    '{4'hE, 4'd0, 4'd10, 4'd4,  4'd2,  1'b1, 1'b1, 4'd10, 32'd8,        4'h2}, // R6 ADDS carry
    '{4'h2, 4'd2, 4'd11, 4'd0,  4'd10, 1'b0, 1'b1, 4'd11, 32'd8,        4'h2}, // R7 CS pass
    '{4'h3, 4'd2, 4'd12, 4'd0,  4'd10, 1'b0, 1'b0, 4'd0,  32'd0,        4'h2}, // R7 CC fail
    '{4'hE, 4'd0, 4'd13, 4'd14, 4'd0,  1'b0, 1'b1, 4'd13, 32'd0,        4'h2}  // R1 regs reset 0
  };

  initial begin
    repeat (60000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 60000, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    // Program 1: predicated straight-line code
    for (int i = 0; i < 64; i++) imem[i] = 32'hF000_0000;
    for (int i = 0; i < NV; i++)
      imem[i] = enc(VEC[i].cond, VEC[i].op, VEC[i].rd, VEC[i].rn, VEC[i].rm, VEC[i].s);
    rst = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 reset fetch address", imem_addr, 32'd0);
    check("R1 reset retire_valid", {31'b0, retire_valid}, 32'd0);
    check("R1 reset flags", {28'b0, flags}, 32'd0);
    n = 0;
    rst = 1'b0;
    for (int k = 0; k < 6; k++) begin
      check("R2 fetch step", imem_addr, 32'(4 * k));
      if (k == 1) check("R1 nothing retired in cycle 2", {31'b0, retire_valid}, 32'd0);
      @(negedge clk);
    end
    repeat (24) @(negedge clk);
    check("R1 first retire cycle", 32'(r_cyc[0]), 32'd2);
    for (int i = 0; i < NV; i++) begin
      check("R2 retire order", r_pc[i], 32'(4 * i));
      check("R4 R7 write enable", {31'b0, r_wen[i]}, {31'b0, VEC[i].ewen});
      if (VEC[i].ewen) begin
        check("R4 destination", {28'b0, r_rd[i]}, {28'b0, VEC[i].erd});
        check("R3 R4 result", r_data[i], VEC[i].edata);
      end
      check("R5 R6 R7 flags", {28'b0, r_fl[i]}, {28'b0, VEC[i].efl});
      check("R8 no redirect", {31'b0, r_tk[i]}, 32'd0);
    end

    // Program 2: branches
    rst = 1'b1;
    for (int i = 0; i < 64; i++) imem[i] = 32'hF000_0000;
    imem[0] = enc(4'hE, 4'd2, 4'd1, 4'd0, 4'd15, 1'b0);   // MOV r1,r15
    imem[1] = enc(4'hE, 4'd3, 4'd0, 4'd1, 4'd1, 1'b0);    // CMP r1,r1 -> Z
    imem[2] = {4'h1, 4'd4, 24'd0};                         // B NE (fails)
    imem[3] = {4'h0, 4'd4, 24'd3};                         // B EQ -> 12+8+12 = 32
    imem[4] = enc(4'hE, 4'd2, 4'd2, 4'd0, 4'd15, 1'b0);   // squashed
    imem[5] = enc(4'hE, 4'd2, 4'd3, 4'd0, 4'd15, 1'b0);   // squashed
    imem[8] = enc(4'hE, 4'd2, 4'd6, 4'd0, 4'd15, 1'b0);   // MOV r6,r15 at 32
    imem[9] = {4'hE, 4'd4, 24'hFFFFFE};                    // B AL to itself (36)
    repeat (3) @(negedge clk);
    n = 0;
    rst = 1'b0;
    repeat (25) @(negedge clk);
    check("R8 not-taken branch pc", r_pc[2], 32'd8);
    check("R8 not-taken flag", {31'b0, r_tk[2]}, 32'd0);
    check("R8 sequential after untaken", r_pc[3], 32'd12);
    check("R9 taken flag", {31'b0, r_tk[3]}, 32'd1);
    check("R9 target retires next", r_pc[4], 32'd32);
    check("R9 two-bubble penalty", 32'(r_cyc[4] - r_cyc[3]), 32'd3);
    check("R3 pc view at target", r_data[4], 32'd40);
    check("R4 target writes r6", {27'b0, r_wen[4], r_rd[4]}, {27'b0, 1'b1, 4'd6});
    check("R9 backward branch pc", r_pc[5], 32'd36);
    check("R9 backward branch taken", {31'b0, r_tk[5]}, 32'd1);
    check("R9 loop returns to itself", r_pc[6], 32'd36);
    check("R9 loop spacing", 32'(r_cyc[6] - r_cyc[5]), 32'd3);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule